// File: doc/BRIEF.md
# Register-Addressed I2C Master Controller

This block is the only master on a two-wire I2C bus that serves one register-addressed slave, such as a real-time clock. A host presents a register pointer, a write byte and a route bit, then pulses a read or a write strobe. When the route bit is 1, the controller runs a fixed sequence on the bus. A write sends the device byte with the write direction, then the pointer, then the data byte, and ends with a STOP. A read first writes the pointer, then issues a repeated START and the device byte with the read direction. It then shifts in one byte, drives an acknowledge and ends with a STOP. When the route bit is 0, the request goes to a separate serial path. The controller raises a one-cycle request for that path and leaves the I2C bus untouched.

The bus lines are open-drain. The block only ever drives a line low or releases it, and it reads the data line back through `sda_in`. SCL is derived from the system clock. Each bit slot is split into four quarters of `QDIV` clocks. A missing acknowledge on any byte the controller sends aborts the transfer with a STOP and sets a sticky error flag. A transfer that completes normally raises a one-cycle done pulse.

Top module: `i2c_reg_master`

## Requirements
- R1: During reset, and whenever no transfer is in progress, both `scl_low` and `sda_low` are 0 (both lines released), and `busy`, `done`, `nack_err` and `uart_req` are 0.
- R2: A write transfer contains exactly one START and one STOP. A read transfer contains exactly two STARTs (the second is a repeated START) and one STOP. Outside these conditions, SDA changes only while SCL is low.
- R3: A write with route bit 1 puts three bytes on the bus, each most significant bit first and each followed by a slave acknowledge slot: 8'hD0 (device 7'h68, direction bit 0), the register pointer, and the write data.
- R4: A read with route bit 1 puts 8'hD0 and the register pointer on the bus, then a repeated START, then 8'hD1 (direction bit 1). It then clocks in one byte, MSB first, and presents that byte on `rd_data` once `busy` falls.
- R5: In the ninth slot after the received byte, the controller drives SDA low (acknowledge).
- R6: A strobe with route bit 0 creates no bus activity. One cycle after the strobe, it raises `uart_req` for exactly one cycle, with `uart_rnw` equal to 1 for a read and 0 for a write.
- R7: If SDA is high in the acknowledge slot of any byte the controller sends, the controller skips the remaining bytes, issues a STOP, returns to idle without `done`, and sets `nack_err`. `nack_err` stays 1 until reset, even after later successful transfers.
- R8: A transfer with no NACK ends with `done` high for exactly one clock, after the STOP.
- R9: Strobes that arrive while `busy` is 1 are ignored. They start no further transfer and raise no `uart_req`.
- R10: When `rd_stb` and `wr_stb` are both high in the same cycle, the request is treated as a read.
- R11: Each SCL period inside a byte lasts 4*QDIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register pointer sent to the slave |
| wr_data | input | 8 | Byte to write |
| wr_stb | input | 1 | Write request strobe |
| rd_stb | input | 1 | Read request strobe |
| route_sel | input | 1 | 1 = I2C bus, 0 = serial side path |
| rd_data | output | 8 | Last byte read from the slave |
| busy | output | 1 | A bus transfer is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| nack_err | output | 1 | Sticky flag: a NACK was seen |
| uart_req | output | 1 | One-cycle request to the serial side path |
| uart_rnw | output | 1 | Direction of the side-path request (1 = read) |
| scl_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The hardest cases to reach from the ports are a NACK partway through a write and the master acknowledge slot that follows a received byte. Both depend on a slave that answers in the right bit slot. The bench therefore models the slave on the wired-AND data line. This model follows SCL edges, acknowledges each byte unless told to refuse a chosen byte index, and drives read data after the read address. It also records the level the controller leaves on the bus in the acknowledge slot of the received byte. Strobes issued in the middle of a running transfer cover the ignore rule, and a strobe with both directions set covers read priority.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BYTE  = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  localparam int unsigned QUARTERS   = 4;
  localparam int unsigned SLOT_BITS  = 9;
  localparam logic [1:0]  STEP_DEV_W = 2'd0;
  localparam logic [1:0]  STEP_PTR   = 2'd1;
  localparam logic [1:0]  STEP_THIRD = 2'd2;
  localparam logic [1:0]  STEP_RECV  = 2'd3;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int unsigned QDIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_line_drv.sv
module i2c_line_drv
  import i2c_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     phase,
  input  logic [1:0] quarter,
  input  logic       bit_rel,
  output logic       scl_low,
  output logic       sda_low
);
  logic scl_lvl, sda_lvl;

  always_comb begin
    scl_lvl = 1'b1;
    sda_lvl = 1'b1;
    case (phase)
      PH_START: begin
        scl_lvl = (quarter == 2'd1) || (quarter == 2'd2);
        sda_lvl = (quarter == 2'd0) || (quarter == 2'd1);
      end
      PH_BYTE: begin
        scl_lvl = (quarter == 2'd1) || (quarter == 2'd2);
        sda_lvl = bit_rel;
      end
      PH_STOP: begin
        scl_lvl = (quarter != 2'd0);
        sda_lvl = quarter[1];
      end
      default: begin
        scl_lvl = 1'b1;
        sda_lvl = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      scl_low <= !scl_lvl;
      sda_low <= !sda_lvl;
    end
  end
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_reg_pkg::*;
#(
  parameter int unsigned QDIV     = 250,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic       route_sel,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done,
  output logic       nack_err,
  output logic       uart_req,
  output logic       uart_rnw,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       sda_in
);
  localparam logic [7:0] DEV_WR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] DEV_RD = {DEV_ADDR, 1'b1};
  localparam logic [3:0] ACK_SLOT = 4'(SLOT_BITS - 1);
  localparam logic [1:0] Q_LAST = 2'(QUARTERS - 1);

  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  phase_t     ph_q, ph_d;
  logic [1:0] q_q, q_d, step_q, step_d;
  logic [3:0] bitn_q, bitn_d;
  logic [7:0] sh_q, sh_d, ptr_q, ptr_d, dat_q, dat_d, rdat_q, rdat_d;
  logic       rdop_q, rdop_d, nak_q, nak_d, bad_q, bad_d, err_q, err_d;
  logic       done_q, done_d, ureq_q, ureq_d, urnw_q, urnw_d;
  logic       tick, rx, bit_rel;

  i2c_qtick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_ns), .run(ph_q != PH_IDLE), .tick(tick)
  );

  assign rx      = (step_q == STEP_RECV);
  assign bit_rel = rx ? (bitn_q != ACK_SLOT)
                      : ((bitn_q == ACK_SLOT) ? 1'b1 : sh_q[7]);

  i2c_line_drv u_line (
    .clk(clk), .rst_n(rst_ns), .phase(ph_q), .quarter(q_q),
    .bit_rel(bit_rel), .scl_low(scl_low), .sda_low(sda_low)
  );

  always_comb begin
    ph_d = ph_q;   step_d = step_q; bitn_d = bitn_q; sh_d = sh_q;
    ptr_d = ptr_q; dat_d = dat_q;   rdat_d = rdat_q; rdop_d = rdop_q;
    nak_d = nak_q; bad_d = bad_q;   err_d = err_q;   urnw_d = urnw_q;
    done_d = 1'b0; ureq_d = 1'b0;
    q_d = (ph_q == PH_IDLE) ? 2'd0 : (tick ? q_q + 2'd1 : q_q);
    case (ph_q)
      PH_IDLE: begin
        if (wr_stb || rd_stb) begin
          if (route_sel) begin
            ph_d   = PH_START;
            step_d = STEP_DEV_W;
            rdop_d = rd_stb;
            ptr_d  = reg_addr;
            dat_d  = wr_data;
            bad_d  = 1'b0;
          end else begin
            ureq_d = 1'b1;
            urnw_d = rd_stb;
          end
        end
      end
      PH_START: begin
        if (tick && q_q == Q_LAST) begin
          ph_d   = PH_BYTE;
          bitn_d = '0;
          sh_d   = (step_q == STEP_DEV_W) ? DEV_WR : DEV_RD;
        end
      end
      PH_BYTE: begin
        if (tick && q_q == 2'd2) begin
          if (rx && bitn_q != ACK_SLOT)  sh_d  = {sh_q[6:0], sda_in};
          if (!rx && bitn_q == ACK_SLOT) nak_d = sda_in;
        end
        if (tick && q_q == Q_LAST) begin
          if (bitn_q != ACK_SLOT) begin
            bitn_d = bitn_q + 4'd1;
            if (!rx) sh_d = {sh_q[6:0], 1'b0};
          end else begin
            bitn_d = '0;
            if (!rx && nak_q) begin
              ph_d  = PH_STOP;
              bad_d = 1'b1;
              err_d = 1'b1;
            end else begin
              case (step_q)
                STEP_DEV_W: begin step_d = STEP_PTR; sh_d = ptr_q; end
                STEP_PTR: begin
                  step_d = STEP_THIRD;
                  if (rdop_q) ph_d = PH_START;
                  else        sh_d = dat_q;
                end
                STEP_THIRD: begin
                  if (rdop_q) step_d = STEP_RECV;
                  else        ph_d   = PH_STOP;
                end
                default: begin
                  ph_d   = PH_STOP;
                  rdat_d = sh_q;
                end
              endcase
            end
          end
        end
      end
      default: begin
        if (tick && q_q == Q_LAST) begin
          ph_d   = PH_IDLE;
          done_d = !bad_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ph_q <= PH_IDLE; q_q <= '0; step_q <= '0; bitn_q <= '0; sh_q <= '0;
      ptr_q <= '0; dat_q <= '0; rdat_q <= '0; rdop_q <= 1'b0; nak_q <= 1'b0;
      bad_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0; ureq_q <= 1'b0;
      urnw_q <= 1'b0;
    end else begin
      ph_q <= ph_d; q_q <= q_d; step_q <= step_d; bitn_q <= bitn_d;
      sh_q <= sh_d; ptr_q <= ptr_d; dat_q <= dat_d; rdat_q <= rdat_d;
      rdop_q <= rdop_d; nak_q <= nak_d; bad_q <= bad_d; err_q <= err_d;
      done_q <= done_d; ureq_q <= ureq_d; urnw_q <= urnw_d;
    end
  end

  assign busy     = (ph_q != PH_IDLE);
  assign done     = done_q;
  assign nack_err = err_q;
  assign uart_req = ureq_q;
  assign uart_rnw = urnw_q;
  assign rd_data  = rdat_q;
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic rd_stb,
  input logic busy,
  input logic done,
  input logic nack_err,
  input logic uart_req,
  input logic scl_low,
  input logic sda_low
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  a_r2_sda_rise_high_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && $fell(sda_low)) |-> busy);

  a_r6_side_path_idle: assert property (@(posedge clk) disable iff (!rst_n)
    uart_req |-> !busy);

  a_r6_side_path_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    uart_req |=> !uart_req);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |=> nack_err);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $stable(nack_err));

  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (wr_stb || rd_stb)) |=> !uart_req);
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .busy(busy), .done(done), .nack_err(nack_err), .uart_req(uart_req),
  .scl_low(scl_low), .sda_low(sda_low)
);

// File: tb/sim_i2c_reg_master.sv
`timescale 1ns/1ps
module sim_i2c_reg_master;
  localparam int unsigned QD = 4;

  logic clk, rst_n;
  logic [7:0] reg_addr, wr_data, rd_data;
  logic wr_stb, rd_stb, route_sel, busy, done, nack_err, uart_req, uart_rnw;
  logic scl_low, sda_low, sda_in, slave_low;

  assign sda_in = !(sda_low || slave_low);

  i2c_reg_master #(.QDIV(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .route_sel(route_sel),
    .rd_data(rd_data), .busy(busy), .done(done), .nack_err(nack_err),
    .uart_req(uart_req), .uart_rnw(uart_rnw), .scl_low(scl_low),
    .sda_low(sda_low), .sda_in(sda_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks, bad, cyc, done_cnt, start_cnt, stop_cnt, nack_at, byte_idx;
  int bitn, last_rise, per_meas;
  bit fin, pscl, psda, slv_tx, pend, mack;
  logic [7:0] sh, rdv;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // monitor and slave model on the wired-AND bus
  always @(negedge clk) begin
    bit scl_lv, sda_lv;
    logic [7:0] e;
    cyc++;
    if (done) done_cnt++;
    if (!rst_n) begin
      pscl = 1; psda = 1; bitn = 0; slv_tx = 0; pend = 0; slave_low = 0; byte_idx = 0;
    end else begin
      scl_lv = !scl_low;
      sda_lv = !(sda_low || slave_low);
      if (scl_lv && pscl && psda && !sda_lv) begin
        start_cnt++; bitn = 0; byte_idx = 0; slv_tx = 0; pend = 0; slave_low = 0;
      end else if (scl_lv && pscl && !psda && sda_lv) begin
        stop_cnt++; bitn = 0; slv_tx = 0; pend = 0; slave_low = 0;
      end else if (scl_lv && !pscl) begin
        if (bitn == 1) per_meas = cyc - last_rise;
        last_rise = cyc;
        if (bitn < 8) begin
          if (!slv_tx) sh = {sh[6:0], sda_lv};
          bitn++;
        end else if (bitn == 8) begin
          if (slv_tx) mack = sda_lv;
          bitn = 9;
        end
      end else if (!scl_lv && pscl) begin
        if (bitn == 8) begin
          if (!slv_tx) begin
            if (exp_q.size() == 0) chk(0, "R3 unexpected byte", sh, 0);
            else begin
              e = exp_q.pop_front();
              chk(sh == e, "R3/R4 bus byte", sh, e);
            end
            slave_low = (nack_at != byte_idx);
            if (sh == 8'hD1) pend = 1;
          end else slave_low = 0;
        end else if (bitn == 9) begin
          bitn = 0; byte_idx++;
          if (pend) begin slv_tx = 1; pend = 0; slave_low = !rdv[7]; end
          else begin slv_tx = 0; slave_low = 0; end
        end else if (bitn >= 1 && bitn <= 7 && slv_tx) begin
          slave_low = !rdv[7 - bitn];
        end
      end
      pscl = scl_lv;
      psda = !(sda_low || slave_low);
    end
    if (cyc > 150000 && !fin) begin
      fin = 1; checks++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic xfer(input bit rd, input bit wr, input bit route,
                      input logic [7:0] ra, input logic [7:0] wd);
    logic [7:0] lst[3];
    int n;
    lst[0] = 8'hD0; lst[1] = ra; lst[2] = rd ? 8'hD1 : wd;
    n = (nack_at >= 0) ? nack_at + 1 : 3;
    if (route) for (int i = 0; i < n; i++) exp_q.push_back(lst[i]);
    @(negedge clk);
    reg_addr = ra; wr_data = wd; wr_stb = wr; rd_stb = rd; route_sel = route;
    @(negedge clk);
    wr_stb = 0; rd_stb = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int s0, p0, d0;
    checks = 0; bad = 0; cyc = 0; done_cnt = 0; start_cnt = 0; stop_cnt = 0;
    fin = 0; nack_at = -1; per_meas = 0; last_rise = 0; mack = 1; rdv = 8'h00; sh = 0;
    rst_n = 0; wr_stb = 0; rd_stb = 0; route_sel = 0; reg_addr = 0; wr_data = 0;
    repeat (5) @(negedge clk);
    chk(!scl_low && !sda_low, "R1 lines in reset", {scl_low, sda_low}, 0);
    chk(!busy && !done && !nack_err && !uart_req, "R1 flags in reset",
        {busy, done, nack_err, uart_req}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!scl_low && !sda_low && !busy, "R1 idle after reset", {scl_low, sda_low, busy}, 0);

    // write 0x5A to pointer 0x07
    s0 = start_cnt; p0 = stop_cnt; d0 = done_cnt;
    xfer(0, 1, 1, 8'h07, 8'h5A); wait_idle();
    chk(exp_q.size() == 0, "R3 all write bytes seen", exp_q.size(), 0);
    chk(start_cnt - s0 == 1, "R2 write starts", start_cnt - s0, 1);
    chk(stop_cnt - p0 == 1, "R2 write stops", stop_cnt - p0, 1);
    chk(done_cnt - d0 == 1, "R8 write done pulse", done_cnt - d0, 1);
    chk(per_meas == 4 * QD, "R11 scl period", per_meas, 4 * QD);
    chk(!nack_err && !scl_low && !sda_low, "R1 released after write",
        {nack_err, scl_low, sda_low}, 0);

    // read pointer 0x03, slave returns 0xA5
    rdv = 8'hA5; mack = 1;
    s0 = start_cnt; p0 = stop_cnt; d0 = done_cnt;
    xfer(1, 0, 1, 8'h03, 8'h00); wait_idle();
    chk(exp_q.size() == 0, "R4 all read bytes seen", exp_q.size(), 0);
    chk(rd_data == 8'hA5, "R4 read data", rd_data, 8'hA5);
    chk(mack == 0, "R5 master ack", mack, 0);
    chk(start_cnt - s0 == 2, "R2 read starts", start_cnt - s0, 2);
    chk(stop_cnt - p0 == 1, "R2 read stops", stop_cnt - p0, 1);
    chk(done_cnt - d0 == 1, "R8 read done pulse", done_cnt - d0, 1);

    // second patterns
    xfer(0, 1, 1, 8'hFF, 8'h00); wait_idle();
    chk(exp_q.size() == 0, "R3 write FF/00", exp_q.size(), 0);
    rdv = 8'h81; mack = 1;
    xfer(1, 0, 1, 8'h3C, 8'h00); wait_idle();
    chk(rd_data == 8'h81, "R4 read data 81", rd_data, 8'h81);
    chk(mack == 0, "R5 master ack 2", mack, 0);

    // side path
    s0 = start_cnt;
    @(negedge clk); wr_stb = 1; route_sel = 0;
    @(negedge clk); wr_stb = 0;
    chk(uart_req && !uart_rnw, "R6 side write req", {uart_req, uart_rnw}, 2);
    @(negedge clk);
    chk(!uart_req, "R6 side req one cycle", uart_req, 0);
    rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    chk(uart_req && uart_rnw, "R6 side read req", {uart_req, uart_rnw}, 3);
    repeat (20) @(negedge clk);
    chk(start_cnt == s0 && !busy && !scl_low && !sda_low, "R6 no bus activity",
        start_cnt - s0, 0);

    // NACK on the pointer byte
    nack_at = 1;
    s0 = start_cnt; p0 = stop_cnt; d0 = done_cnt;
    xfer(0, 1, 1, 8'h11, 8'h22); wait_idle();
    nack_at = -1;
    chk(nack_err == 1, "R7 error set", nack_err, 1);
    chk(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
    chk(stop_cnt - p0 == 1 && !busy, "R7 stop and idle", stop_cnt - p0, 1);
    chk(exp_q.size() == 0, "R7 bytes up to nack", exp_q.size(), 0);

    // error stays after a clean write
    d0 = done_cnt;
    xfer(0, 1, 1, 8'h12, 8'h34); wait_idle();
    chk(done_cnt - d0 == 1 && nack_err, "R7 sticky after success",
        {nack_err, 4'(done_cnt - d0)}, 17);

    // strobes during a transfer are ignored
    s0 = start_cnt;
    xfer(0, 1, 1, 8'h44, 8'h99);
    repeat (40) @(negedge clk);
    rd_stb = 1; wr_stb = 1; route_sel = 1; reg_addr = 8'hEE;
    @(negedge clk); rd_stb = 0; wr_stb = 0; route_sel = 0;
    @(negedge clk); wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    chk(!uart_req, "R9 no side req while busy", uart_req, 0);
    wait_idle(); repeat (30) @(negedge clk);
    chk(start_cnt - s0 == 1 && exp_q.size() == 0, "R9 single transfer",
        start_cnt - s0, 1);

    // both strobes -> read
    rdv = 8'h6C;
    xfer(1, 1, 1, 8'h05, 8'h77); wait_idle();
    chk(exp_q.size() == 0 && rd_data == 8'h6C, "R10 read wins", rd_data, 8'h6C);

    if (!fin) begin
      fin = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule